// File: doc/BRIEF.md
# Interpolated Half-Sine Table Oscillator

This block is a numerically controlled sine oscillator that steps once for every audio sample strobe. A phase register made of a 10-bit integer part over an 8-bit fraction advances by a 16-bit increment on each strobe. The integer part picks two neighbouring points of a full sine period. Only one half-period is stored, as 512 magnitudes of 16 bits. The other half is rebuilt by negating what the table returns. The two points are blended by linear interpolation, with the phase fraction as the weight. The result leaves the block as one signed 16-bit sample per strobe.

The output frequency is proportional to the increment. An increment of 256 moves exactly one table point per strobe, so a full period takes 1024 strobes. Smaller increments give fractional steps, and the interpolation covers the points in between. The ROM contents are computed when the design is elaborated, so no external data file is needed.

The output is a stream that carries a valid flag and no ready. The sample rate is set by the strobe, so the consumer cannot apply back-pressure. It must take each sample in the cycle where the valid flag is high. The sample then stays on the output until the next one replaces it.

Top module: `hsnco_osc`

## Requirements
- R1: Table entry k (k = 0..511) holds round(32767 * sin(pi * k / 512)), which is never negative.
- R2: When phase index bit 9 is 1 (index 512..1023), the sample taken from table entry index[8:0] is negated. Index bit 9 is phase bit 17.
- R3: Phase is 18 bits: the index is in bits [17:8] and the fraction in bits [7:0]. Each sampled strobe adds the zero-extended 16-bit increment and wraps modulo 2^18. Without a strobe the phase holds.
- R4: Reset (rst_ni low, asynchronous) clears the phase to 0, the sample to 0 and the valid flag to 0.
- R5: For index i, fraction f and rebuilt samples s0 (at i) and s1 (at i+1), the output is floor(s0*(255-f)/256) + floor(s1*f/256).
- R6: s1 is taken from index (i+1) mod 1024 and gets its own sign test, so the blend is correct across the 511/512 and 1023/0 boundaries.
- R7: For a strobe sampled at clock edge E, sample_valid_o is high for exactly the cycle after edge E+1. The sample computed then uses the phase that already includes that strobe's increment.
- R8: Without a strobe, sample_valid_o stays low and sample_o keeps its last value.
- R9: Strobes on consecutive cycles each produce their own valid sample on consecutive cycles.
- R10: An increment of 256 steps exactly one table point per strobe, so the waveform repeats every 1024 strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 1 | Sample strobe: advance the phase and produce one sample |
| incr_i | input | 16 | Phase increment, 8 fraction bits, sampled with strobe_i |
| sample_o | output | 16 | Signed interpolated sine sample |
| sample_valid_o | output | 1 | High for one cycle for each new sample |

## Verification
The bench sweeps half-point and whole-point increments over more than a full period. This exercises the 511/512 and 1023/0 crossings. A design that tested the sign only once for both points, or did not wrap index+1, would give a sharp step at the zero crossings. A unit increment sweeps every fraction value, which exposes a swapped or non-complemented weight. Increments of 0xFFFF and a pseudo-random pattern test the carry from the fraction into the index and the phase wrap. Strobes on consecutive cycles and a reset in mid-run catch a pipeline that drops samples or keeps stale phase.

// File: rtl/hsnco_pkg.sv
package hsnco_pkg;

  localparam real HSNCO_PI = 3.14159265358979323846;

  // Rounded magnitude of a half-period sine point.
  function automatic int sine_mag(input int k, input int npts, input int amp);
    real x;
    x = real'(amp) * $sin(HSNCO_PI * real'(k) / real'(npts));
    if (x < 0.0) x = 0.0;
    return $rtoi(x + 0.5);
  endfunction

endpackage

// File: rtl/hsnco_phase_acc.sv
module hsnco_phase_acc #(
  parameter int INT_W  = 10,
  parameter int FRAC_W = 8,
  parameter int INC_W  = 16
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      step_i,
  input  logic [INC_W-1:0]          incr_i,
  output logic [INT_W+FRAC_W-1:0]   phase_o
);
  localparam int PH_W  = INT_W + FRAC_W;
  localparam int SUM_W = PH_W + INC_W;

  logic [PH_W-1:0]  phase_q;
  logic [SUM_W-1:0] wide_sum;

  assign wide_sum = SUM_W'(phase_q) + SUM_W'(incr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= '0;
    else if (step_i) phase_q <= wide_sum[PH_W-1:0];
  end

  assign phase_o = phase_q;

  // R3: phase holds when no strobe arrives
  a_r3_phase_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(phase_q));

endmodule

// File: rtl/hsnco_halfsine_rom.sv
module hsnco_halfsine_rom
  import hsnco_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int SAMP_W = 16,
  parameter int AMP    = 32767,
  parameter int NPORT  = 2
) (
  input  logic [NPORT-1:0][ADDR_W:0]         idx_i,
  output logic [NPORT-1:0][SAMP_W-1:0]       samp_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [SAMP_W-1:0] mag_mem [DEPTH];

  initial begin
    for (int k = 0; k < DEPTH; k++) mag_mem[k] = SAMP_W'(sine_mag(k, DEPTH, AMP));
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic [SAMP_W-1:0] mag;
    logic              neg_half;
    assign mag      = mag_mem[idx_i[p][ADDR_W-1:0]];
    assign neg_half = idx_i[p][ADDR_W];
    assign samp_o[p] = neg_half ? (~mag + 1'b1) : mag;

    // R1, R2: first half never negative, second half never positive
    always_comb begin
      a_r2_sign_half: assert (neg_half ? ($signed(samp_o[p]) <= 0) : ($signed(samp_o[p]) >= 0));
      a_r1_mag_range: assert ($signed(mag) >= 0 && int'($signed(mag)) <= AMP);
    end
  end

endmodule

// File: rtl/hsnco_lerp.sv
module hsnco_lerp #(
  parameter int SAMP_W = 16,
  parameter int FRAC_W = 8
) (
  input  logic [SAMP_W-1:0] s0_i,
  input  logic [SAMP_W-1:0] s1_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic [SAMP_W-1:0] blend_o
);
  localparam int P_W = SAMP_W + FRAC_W + 1;
  localparam int H_W = SAMP_W + 1;

  logic [FRAC_W-1:0]       w0, w1;
  logic signed [P_W-1:0]   a0, a1, b0, b1, p0, p1;
  logic signed [H_W-1:0]   h0, h1, sum;

  assign w0 = ~frac_i;
  assign w1 = frac_i;
  assign a0 = P_W'($signed(s0_i));
  assign a1 = P_W'($signed(s1_i));
  assign b0 = $signed(P_W'(w0));
  assign b1 = $signed(P_W'(w1));
  assign p0 = a0 * b0;
  assign p1 = a1 * b1;
  assign h0 = p0[P_W-1 -: H_W];
  assign h1 = p1[P_W-1 -: H_W];
  assign sum = h0 + h1;
  assign blend_o = sum[SAMP_W-1:0];

  // R5: the blended sum always fits the output width
  always_comb begin
    a_r5_no_overflow: assert (sum[H_W-1] == sum[H_W-2]);
  end

endmodule

// File: rtl/hsnco_osc.sv
module hsnco_osc #(
  parameter int ADDR_W = 9,
  parameter int FRAC_W = 8,
  parameter int INC_W  = 16,
  parameter int SAMP_W = 16,
  parameter int AMP    = 32767
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_i,
  input  logic [15:0]       incr_i,
  output logic [15:0]       sample_o,
  output logic              sample_valid_o
);
  localparam int INT_W = ADDR_W + 1;
  localparam int PH_W  = INT_W + FRAC_W;

  logic [PH_W-1:0]            phase;
  logic [1:0][INT_W-1:0]      rd_idx;
  logic [1:0][SAMP_W-1:0]     rd_samp;
  logic [SAMP_W-1:0]          blend;
  logic                       pend_q;
  logic [SAMP_W-1:0]          samp_q;
  logic                       vld_q;

  hsnco_phase_acc #(.INT_W(INT_W), .FRAC_W(FRAC_W), .INC_W(INC_W)) u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (strobe_i),
    .incr_i  (INC_W'(incr_i)),
    .phase_o (phase)
  );

  assign rd_idx[0] = phase[PH_W-1:FRAC_W];
  assign rd_idx[1] = rd_idx[0] + 1'b1;

  hsnco_halfsine_rom #(.ADDR_W(ADDR_W), .SAMP_W(SAMP_W), .AMP(AMP), .NPORT(2)) u_rom (
    .idx_i  (rd_idx),
    .samp_o (rd_samp)
  );

  hsnco_lerp #(.SAMP_W(SAMP_W), .FRAC_W(FRAC_W)) u_lerp (
    .s0_i    (rd_samp[0]),
    .s1_i    (rd_samp[1]),
    .frac_i  (phase[FRAC_W-1:0]),
    .blend_o (blend)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      vld_q  <= 1'b0;
      samp_q <= '0;
    end else begin
      pend_q <= strobe_i;
      vld_q  <= pend_q;
      if (pend_q) samp_q <= blend;
    end
  end

  assign sample_o       = 16'(samp_q);
  assign sample_valid_o = vld_q;

  // R7: a strobe yields a valid sample two edges later
  a_r7_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |=> ##1 sample_valid_o);
  // R8: no strobe, no valid and the sample holds
  a_r8_quiet_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> ##1 (!sample_valid_o && $stable(sample_o)));
  // R5: output never exceeds table amplitude
  a_r5_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_valid_o |-> ($signed(sample_o) <= AMP && $signed(sample_o) >= -AMP - 1));

endmodule

// File: tb/hsnco_osc_tb_top.sv
`timescale 1ns/1ps
module hsnco_osc_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strobe = 1'b0;
  logic [15:0] incr = '0;
  logic [15:0] samp;
  logic        vld;

  int total = 0;
  int bad   = 0;
  int exp_ph = 0;

  always #2.5 clk = ~clk;

  hsnco_osc dut_i (
    .clk_i(clk), .rst_ni(rst_n), .strobe_i(strobe), .incr_i(incr),
    .sample_o(samp), .sample_valid_o(vld)
  );

  function automatic int tbl(input int k);
    real x;
    x = 32767.0 * $sin(3.14159265358979323846 * real'(k) / 512.0);
    if (x < 0.0) x = 0.0;
    return $rtoi(x + 0.5);
  endfunction

  function automatic int rebuilt(input int idx);
    int m;
    m = tbl(idx % 512);
    return (idx >= 512) ? -m : m;
  endfunction

  function automatic int expect_of(input int ph);
    int i, f, s0, s1;
    i  = (ph >> 8) % 1024;
    f  = ph & 255;
    s0 = rebuilt(i);
    s1 = rebuilt((i + 1) % 1024);
    return ((s0 * (255 - f)) >>> 8) + ((s1 * f) >>> 8);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, expv);
    end
  endtask

  // One isolated strobe: sample valid at the third negedge, low at the fourth
  task automatic one_strobe(input logic [15:0] inc, input string req);
    int e;
    @(negedge clk); strobe = 1'b1; incr = inc;
    @(negedge clk); strobe = 1'b0;
    exp_ph = (exp_ph + int'(inc)) % 262144;
    e = expect_of(exp_ph);
    @(negedge clk);
    chk(vld == 1'b1, "R7 valid", int'(vld), 1);
    chk(int'($signed(samp)) == e, req, int'($signed(samp)), e);
    @(negedge clk);
    chk(vld == 1'b0, "R8 valid single", int'(vld), 0);
  endtask

  initial begin
    #(5.0 * 190000);
    total++; bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    logic [15:0] held;
    repeat (3) @(negedge clk);
    chk(vld == 1'b0, "R4 reset valid", int'(vld), 0);
    chk(samp == 16'd0, "R4 reset sample", int'($signed(samp)), 0);
    rst_n = 1'b1;

    // R10 / R1: one point per strobe, more than a full period
    for (int n = 0; n < 1100; n++) one_strobe(16'd256, "R10 R1 whole-point step");

    // R6 / R2: half-point steps cross 511/512 and 1023/0
    for (int n = 0; n < 2100; n++) one_strobe(16'd128, "R6 R2 half-point crossing");

    // R5: fraction sweep with unit increment
    for (int n = 0; n < 300; n++) one_strobe(16'd1, "R5 fraction sweep");

    // R3: large increment, carries and wrap
    for (int n = 0; n < 300; n++) one_strobe(16'hFFFF, "R3 max increment wrap");

    // R3: pseudo-random increments
    lfsr = 16'hACE1;
    for (int n = 0; n < 500; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      one_strobe(lfsr, "R3 random increment");
    end

    // R8: idle cycles keep the sample and valid low
    held = samp;
    repeat (20) @(negedge clk);
    chk(vld == 1'b0, "R8 idle valid", int'(vld), 0);
    chk(samp == held, "R8 idle hold", int'($signed(samp)), int'($signed(held)));

    // R9: four back-to-back strobes
    begin
      int eq[4];
      @(negedge clk); strobe = 1'b1; incr = 16'd777;
      for (int k = 0; k < 4; k++) begin
        exp_ph = (exp_ph + 777) % 262144;
        eq[k] = expect_of(exp_ph);
      end
      @(negedge clk);
      @(negedge clk);
      for (int k = 0; k < 4; k++) begin
        if (k == 2) strobe = 1'b0;
        chk(vld == 1'b1, "R9 back-to-back valid", int'(vld), 1);
        chk(int'($signed(samp)) == eq[k], "R9 back-to-back sample", int'($signed(samp)), eq[k]);
        @(negedge clk);
      end
      chk(vld == 1'b0, "R9 stream end", int'(vld), 0);
    end

    // R4: reset in mid-run clears phase and output
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk(vld == 1'b0, "R4 mid reset valid", int'(vld), 0);
    chk(samp == 16'd0, "R4 mid reset sample", int'($signed(samp)), 0);
    rst_n = 1'b1;
    exp_ph = 0;
    for (int n = 0; n < 8; n++) one_strobe(16'd300, "R4 restart from zero phase");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule